// File: doc/BRIEF.md
# Twiddled Texture Address Generator

This block turns a texel coordinate into the linear offset of that texel inside a texture stored in interleaved (Morton-style) order. The texture sides are powers of two, from 1 to 1024 texels, and the two sides need not be equal. The offset is built from the least significant bit upward: each step takes one bit of the row coordinate and then one bit of the column coordinate. An axis stops giving bits once all of its bits are used. After that, the remaining bits of the longer axis follow one after another.

For square mipmapped textures the block also gives the start of the selected mip level, measured from the texture start. In that mode both sides take the level size, and the separate height code is ignored. The level start comes from a fixed series of offsets. Direct-colour formats scale that series by bits per texel; the vector-quantized format uses a series of its own.

A texture-fetch pipeline presents a coordinate with a strobe. The result comes out of a register one clock later, with its own strobe. The block accepts a new coordinate on every clock.

Top module: `twiddle_addr_gen`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. During reset `out_valid`, `out_offset` and `out_base` are 0.
- R2: For a square texture of side 2^n, bit 2k of `out_offset` is y[k] and bit 2k+1 is x[k], for k < n. All higher bits are 0.
- R3: For unequal sides, a step k places y[k] only if k < log2 height, and then x[k] only if k < log2 width. Each placed bit takes the next free position, counting from bit 0.
- R4: Coordinate bits at or above the log2 of their axis size have no effect on `out_offset`.
- R5: Any size log2 value (`in_wlog`, `in_hlog`, `in_level`) above 10 is treated as 10.
- R6: When `in_mip` is 1, both axes use the log2 size `in_level`, and `in_hlog` and `in_wlog` have no effect.
- R7: When `in_mip` is 1 and `in_vq` is 0, `out_base` is (T[level] * b) / 8 with integer division. T is 3, 4, 8, 0x18, 0x58, 0x158, 0x558, 0x1558, 0x5558, 0x15558, 0x55558 for levels 0 to 10. The factor b comes from `in_bpp`: 0 gives 4, 1 gives 8, and 2 or 3 give 16.
- R8: When `in_mip` is 1 and `in_vq` is 1, `out_base` is 0, 1, 2, 6, 0x16, 0x56, 0x156, 0x556, 0x1556, 0x5556, 0x15556 for levels 0 to 10. `in_bpp` has no effect in this mode.
- R9: When `in_mip` is 0, `out_base` is 0. In a cycle with `in_valid` low, `out_offset` and `out_base` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Coordinate strobe |
| in_x | input | 10 | Column coordinate |
| in_y | input | 10 | Row coordinate |
| in_wlog | input | 4 | log2 of width (non-mip mode) |
| in_hlog | input | 4 | log2 of height (non-mip mode) |
| in_mip | input | 1 | Square mipmapped addressing |
| in_level | input | 4 | log2 of the mip level side (0 = 1x1) |
| in_vq | input | 1 | Vector-quantized level offset series |
| in_bpp | input | 2 | Bits per texel code: 0=4, 1=8, 2/3=16 |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_offset | output | 20 | Interleaved texel offset |
| out_base | output | 24 | Mip level start offset |

## Verification
In mip mode, the level start and the interleaved offset inside that level are both derived from the single `in_level` field and update on the same edge. A fault in the shared level clamp or decode would therefore show up in both at once. The bench provokes this by streaming back-to-back strobes that step through every level, with a different format on each strobe. It sets a deliberately wrong `in_hlog` at the same time. Each cycle's offset is judged against a halving-counter loop model, and its base against the literal offset series, independently of each other.

// File: rtl/twiddle_pkg.sv
package twiddle_pkg;
  typedef enum logic [1:0] {
    BPP_4    = 2'd0,
    BPP_8    = 2'd1,
    BPP_16   = 2'd2,
    BPP_16B  = 2'd3
  } bpp_e;
endpackage

// File: rtl/twiddle_dim_sel.sv
module twiddle_dim_sel #(
  parameter int LOG_MAX = 10,
  localparam int LW = $clog2(LOG_MAX + 1)
) (
  input  logic [LW-1:0] wlog,
  input  logic [LW-1:0] hlog,
  input  logic [LW-1:0] level,
  input  logic          mip,
  output logic [LW-1:0] ew,
  output logic [LW-1:0] eh,
  output logic [LW-1:0] lvl
);
  function automatic logic [LW-1:0] clamp_log(logic [LW-1:0] v);
    return (int'(v) > LOG_MAX) ? LW'(LOG_MAX) : v;
  endfunction

  assign lvl = clamp_log(level);
  assign ew  = mip ? lvl : clamp_log(wlog);
  assign eh  = mip ? lvl : clamp_log(hlog);
endmodule

// File: rtl/twiddle_interleave.sv
module twiddle_interleave #(
  parameter int LOG_MAX = 10,
  localparam int LW = $clog2(LOG_MAX + 1),
  localparam int CW = LOG_MAX,
  localparam int OW = 2 * LOG_MAX,
  localparam int PW = $clog2(OW + 1)
) (
  input  logic [CW-1:0] xv,
  input  logic [CW-1:0] yv,
  input  logic [LW-1:0] ew,
  input  logic [LW-1:0] eh,
  output logic [OW-1:0] offset
);
  function automatic logic [OW-1:0] weave(logic [CW-1:0] xi, logic [CW-1:0] yi,
                                           logic [LW-1:0] wl, logic [LW-1:0] hl);
    logic [OW-1:0] r;
    logic [PW-1:0] p;
    r = '0;
    p = '0;
    for (int k = 0; k < LOG_MAX; k++) begin
      if (k < int'(hl)) begin
        r[p] = yi[k];
        p = p + PW'(1);
      end
      if (k < int'(wl)) begin
        r[p] = xi[k];
        p = p + PW'(1);
      end
    end
    return r;
  endfunction

  // masks of the bits that each axis may contribute
  logic [CW-1:0] x_keep, y_keep;
  assign x_keep = CW'((1 << ew) - 1);
  assign y_keep = CW'((1 << eh) - 1);

  assign offset = weave(xv, yv, ew, eh);

  // R2 / R3: the interleave moves bits, it neither creates nor drops them
  always_comb begin
    a_r3_bits_preserved: assert ($countones(offset) ==
                                 $countones(xv & x_keep) + $countones(yv & y_keep));
  end
endmodule

// File: rtl/twiddle_mip_base.sv
module twiddle_mip_base
  import twiddle_pkg::*;
#(
  parameter int LOG_MAX = 10,
  parameter int BW = 24,
  localparam int LW = $clog2(LOG_MAX + 1)
) (
  input  logic [LW-1:0] lvl,
  input  logic          vq,
  input  bpp_e          bpp,
  output logic [BW-1:0] base
);
  // direct-colour series in texels: 3, 4, then each step adds 4^(i-1)
  function automatic int plain_texels(int l);
    int t;
    t = (l >= 1) ? 4 : 3;
    for (int i = 2; i <= LOG_MAX; i++)
      if (i <= l) t = t + (1 << (2 * (i - 1)));
    return t;
  endfunction

  // vector-quantized series: 0, 1, then each step adds 4^(i-2)
  function automatic int vq_offset(int l);
    int v;
    v = (l >= 1) ? 1 : 0;
    for (int i = 2; i <= LOG_MAX; i++)
      if (i <= l) v = v + (1 << (2 * (i - 2)));
    return v;
  endfunction

  function automatic int scale_bpp(int t, bpp_e b);
    case (b)
      BPP_4:   return t >> 1;
      BPP_8:   return t;
      default: return t << 1;
    endcase
  endfunction

  int plain_sel, vq_sel;
  assign plain_sel = scale_bpp(plain_texels(int'(lvl)), bpp);
  assign vq_sel    = vq_offset(int'(lvl));
  assign base      = vq ? BW'(vq_sel) : BW'(plain_sel);
endmodule

// File: rtl/twiddle_addr_gen.sv
module twiddle_addr_gen
  import twiddle_pkg::*;
#(
  parameter int LOG_MAX = 10,
  parameter int BW = 24,
  localparam int LW = $clog2(LOG_MAX + 1),
  localparam int CW = LOG_MAX,
  localparam int OW = 2 * LOG_MAX
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [CW-1:0] in_x,
  input  logic [CW-1:0] in_y,
  input  logic [LW-1:0] in_wlog,
  input  logic [LW-1:0] in_hlog,
  input  logic          in_mip,
  input  logic [LW-1:0] in_level,
  input  logic          in_vq,
  input  logic [1:0]    in_bpp,
  output logic          out_valid,
  output logic [OW-1:0] out_offset,
  output logic [BW-1:0] out_base
);
  logic [LW-1:0] ew, eh, lvl;
  logic [OW-1:0] offset_c;
  logic [BW-1:0] base_c;
  logic [LW:0]   bits_used;   // total offset bits this request may use

  twiddle_dim_sel #(.LOG_MAX(LOG_MAX)) u_dims (
    .wlog(in_wlog), .hlog(in_hlog), .level(in_level), .mip(in_mip),
    .ew(ew), .eh(eh), .lvl(lvl)
  );

  twiddle_interleave #(.LOG_MAX(LOG_MAX)) u_weave (
    .xv(in_x), .yv(in_y), .ew(ew), .eh(eh), .offset(offset_c)
  );

  twiddle_mip_base #(.LOG_MAX(LOG_MAX), .BW(BW)) u_base (
    .lvl(lvl), .vq(in_vq), .bpp(bpp_e'(in_bpp)), .base(base_c)
  );

  assign bits_used = {1'b0, ew} + {1'b0, eh};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_offset <= '0;
      out_base   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_offset <= offset_c;
        out_base   <= in_mip ? base_c : '0;
      end
    end
  end

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r4_offset_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_offset >> $past(bits_used)) == '0);
  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_offset) && $stable(out_base));
  a_r9_base_zero_flat: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_mip |=> out_base == '0);
  a_r8_vq_level0_zero: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_mip && in_vq && in_level == '0 |=> out_base == '0);
endmodule

// File: tb/twiddle_addr_gen_test.sv
module twiddle_addr_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [9:0]  in_x = '0, in_y = '0;
  logic [3:0]  in_wlog = '0, in_hlog = '0, in_level = '0;
  logic        in_mip = 1'b0, in_vq = 1'b0;
  logic [1:0]  in_bpp = '0;
  logic        out_valid;
  logic [19:0] out_offset;
  logic [23:0] out_base;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  twiddle_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
    .in_wlog(in_wlog), .in_hlog(in_hlog), .in_mip(in_mip), .in_level(in_level),
    .in_vq(in_vq), .in_bpp(in_bpp), .out_valid(out_valid),
    .out_offset(out_offset), .out_base(out_base)
  );

  int plain_tab[11] = '{3, 4, 8, 'h18, 'h58, 'h158, 'h558, 'h1558, 'h5558, 'h15558, 'h55558};
  int vq_tab[11]    = '{0, 1, 2, 6, 'h16, 'h56, 'h156, 'h556, 'h1556, 'h5556, 'h15556};

  // halving-counter model of the interleave
  function automatic int m_weave(int x, int y, int wl, int hl);
    int xs, ys, rv, sh;
    xs = (1 << wl) >> 1;
    ys = (1 << hl) >> 1;
    rv = 0;
    sh = 0;
    while (xs != 0 || ys != 0) begin
      if (ys != 0) begin rv |= (y & 1) << sh; ys >>= 1; y >>= 1; sh++; end
      if (xs != 0) begin rv |= (x & 1) << sh; xs >>= 1; x >>= 1; sh++; end
    end
    return rv;
  endfunction

  function automatic int lim(int v);
    return v > 10 ? 10 : v;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // one request; checked one edge later
  task automatic apply(int x, int y, int wl, int hl, bit mip, int lv, bit vq, int bpp, string req);
    int ew, eh, eo, eb, bits;
    @(negedge clk);
    in_valid = 1'b1;
    in_x = 10'(x); in_y = 10'(y);
    in_wlog = 4'(wl); in_hlog = 4'(hl);
    in_mip = mip; in_level = 4'(lv); in_vq = vq; in_bpp = 2'(bpp);
    @(posedge clk);
    #1;
    ew = mip ? lim(lv) : lim(wl);
    eh = mip ? lim(lv) : lim(hl);
    eo = m_weave(x, y, ew, eh);
    bits = (bpp == 0) ? 4 : (bpp == 1) ? 8 : 16;
    if (!mip) eb = 0;
    else if (vq) eb = vq_tab[lim(lv)];
    else eb = plain_tab[lim(lv)] * bits / 8;
    check(out_valid == 1'b1, "R1", int'(out_valid), 1);
    check(int'(out_offset) == eo, req, int'(out_offset), eo);
    check(int'(out_base) == eb, !mip ? "R9" : (vq ? "R8" : "R7"), int'(out_base), eb);
  endtask

  task automatic go_idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    check(out_valid == 1'b0, "R1 reset valid", int'(out_valid), 0);
    check(out_offset == '0, "R1 reset offset", int'(out_offset), 0);
    check(out_base == '0, "R1 reset base", int'(out_base), 0);
  endtask

  // R2 and R3: every size pair up to 64x64, every coordinate
  task automatic t_sweep();
    for (int wl = 0; wl <= 6; wl++)
      for (int hl = 0; hl <= 6; hl++)
        for (int y = 0; y < (1 << hl); y++)
          for (int x = 0; x < (1 << wl); x++)
            apply(x, y, wl, hl, 0, 0, 0, 0, (wl == hl) ? "R2" : "R3");
    go_idle();
  endtask

  task automatic t_square_spot();
    // 4x4, x=3 y=0 -> bits 1 and 3 -> 0xA ; x=0 y=3 -> 0x5
    apply(3, 0, 2, 2, 0, 0, 0, 0, "R2");
    check(out_offset == 20'hA, "R2 x only", int'(out_offset), 'hA);
    apply(0, 3, 2, 2, 0, 0, 0, 0, "R2");
    check(out_offset == 20'h5, "R2 y only", int'(out_offset), 'h5);
    // 8 wide, 2 high: y0 x0 x1 x2 -> x=7 y=1 -> 0xF, x=4 y=0 -> 0x8
    apply(4, 0, 3, 1, 0, 0, 0, 0, "R3");
    check(out_offset == 20'h8, "R3 tail", int'(out_offset), 'h8);
    go_idle();
  endtask

  task automatic t_large();
    for (int i = 0; i < 300; i++)
      apply(int'($urandom_range(1023)), int'($urandom_range(1023)), 10,
            (i % 3 == 0) ? 10 : int'($urandom_range(10)), 0, 0, 0, 0, "R3");
    apply(1023, 1023, 10, 10, 0, 0, 0, 0, "R2");
    check(out_offset == 20'hFFFFF, "R2 full", int'(out_offset), 'hFFFFF);
    go_idle();
  endtask

  task automatic t_mask();
    // 4x2 texture, high coordinate bits set must not matter
    apply(10'h3F9, 10'h2A2, 2, 1, 0, 0, 0, 0, "R4");
    apply(1, 0, 2, 1, 0, 0, 0, 0, "R4");
    check(out_offset == 20'h2, "R4 masked", int'(out_offset), 2);
    apply(10'h3FF, 10'h3FF, 0, 0, 0, 0, 0, 0, "R4");
    check(out_offset == 20'h0, "R4 1x1", int'(out_offset), 0);
    go_idle();
  endtask

  task automatic t_clamp();
    apply(1023, 5, 15, 11, 0, 0, 0, 0, "R5");
    apply(7, 9, 12, 3, 0, 0, 0, 0, "R5");
    apply(3, 3, 0, 0, 1, 14, 0, 2, "R5");
    apply(3, 3, 0, 0, 1, 13, 1, 0, "R5");
    go_idle();
  endtask

  // level start and in-level offset together, back to back
  task automatic t_mip();
    for (int lv = 0; lv <= 10; lv++)
      for (int b = 0; b < 4; b++)
        apply(int'($urandom_range(1023)), int'($urandom_range(1023)),
              (lv + 3) % 11, (lv + 5) % 11, 1, lv, 0, b, "R6");
    for (int lv = 0; lv <= 10; lv++)
      apply(int'($urandom_range(1023)), int'($urandom_range(1023)), 1, 9, 1, lv, 1,
            lv % 4, "R6");
    apply(1, 0, 0, 7, 1, 0, 0, 0, "R7");
    check(out_base == 24'd1, "R7 4bpp level0 truncated", int'(out_base), 1);
    apply(0, 0, 0, 0, 1, 10, 0, 2, "R7");
    check(out_base == 24'hAAAB0, "R7 16bpp level10", int'(out_base), 'hAAAB0);
    go_idle();
  endtask

  task automatic t_hold();
    int o, b;
    apply(5, 6, 3, 3, 1, 4, 0, 1, "R6");
    o = int'(out_offset);
    b = int'(out_base);
    @(negedge clk);
    in_valid = 1'b0;
    in_x = 10'h155; in_y = 10'h2AA; in_mip = 1'b0; in_level = 4'd9;
    @(posedge clk);
    #1;
    check(out_valid == 1'b0, "R1 drop", int'(out_valid), 0);
    check(int'(out_offset) == o, "R9 hold offset", int'(out_offset), o);
    check(int'(out_base) == b, "R9 hold base", int'(out_base), b);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    t_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_square_spot();
    t_mask();
    t_clamp();
    t_mip();
    t_hold();
    t_large();
    t_sweep();
    done = 1;
    finish_run();
  end
endmodule